// File: doc/BRIEF.md
# Serial EEPROM Transaction Sequencer

This block is a hardware SPI master that carries out complete read and write transactions on a serial EEPROM. A client issues one request that names the operation, an address of 0 to `ADDR_MAX` bytes, and a payload length. The block then drives chip select, the serial clock and the outgoing data line by itself, one 8-bit character at a time, and samples the incoming data line. Write payload comes in on a byte stream with a valid/ready handshake. Read data goes out on a second byte stream with the same handshake. The serial clock stops between characters whenever either stream stalls.

A write takes two chip-select frames. The first carries only the write-enable opcode. The second carries the write opcode, the address and the payload. The block then polls the device's status until its busy flag clears, with a bounded number of attempts and a fixed wait between them. Running out of attempts ends the transaction with an error. A read takes one frame. The bytes that arrive while the opcode and address go out are thrown away, and so is one extra trailing byte that the frame always clocks. Requests that would not fit in one frame are refused without touching the bus.

Top module: `spi_eeprom_seq`

## Requirements
- R1: The serial clock idles low. Each high phase lasts exactly `CLK_DIV` system cycles. Outgoing data changes only while the clock is low, and it is sampled on the rising edge. Characters are 8 bits and go out most significant bit first.
- R2: `cs_n` stays low for every byte of a frame, is high whenever the block is idle, and stays high for at least `2*CLK_DIV` cycles between two frames.
- R3: A read frame holds, in this order: opcode 0x03, the `req_alen` low-order bytes of `req_addr` (most significant first), and then `req_len + 1` further bytes. It is `2 + req_alen + req_len` bytes long.
- R4: A read delivers exactly `req_len` bytes on `rd_data`, in order. These are the bytes received at frame positions `req_alen+1` up to `req_alen+req_len`. `rd_valid` and `rd_data` hold steady until `rd_ready` accepts the byte.
- R5: A write sends a one-byte frame holding 0x06. It then sends a frame holding 0x02, the address bytes as in R3, and `req_len` payload bytes, each taken from `wr_data` through the valid/ready handshake.
- R6: After the write frame, each status poll is a two-byte frame, 0x05 followed by 0x00. Bit 0 of the second received byte is the busy flag. Polling stops at the first poll that reads 0, and `done` then comes with `err`=0.
- R7: If `POLL_LIMIT` polls in a row all read busy, the transaction ends with `done` and `err`=1. Between two polls `cs_n` stays high for at least `POLL_WAIT` cycles.
- R8: A request with `req_alen > ADDR_MAX`, or whose frame (opcode + address + payload, plus 1 for a read) would exceed `MAX_FRAME` bytes, produces `done` with `err`=1 on the next cycle. No frame is sent.
- R9: A request is taken only when `busy` is low. `busy` is high from the cycle after an accepted request until `done`. `done` is a one-cycle pulse with `busy` low.
- R10: After reset, `cs_n`=1, `sclk`=0, `busy`=0, `done`=0, `rd_valid`=0 and `wr_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_write | input | 1 | 1 = write transaction, 0 = read |
| req_alen | input | clog2(ADDR_MAX+1) | Number of address bytes |
| req_addr | input | 8*ADDR_MAX | Address; the low `req_alen` bytes are sent |
| req_len | input | clog2(MAX_FRAME+1) | Payload length in bytes |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error qualifier, valid with `done` |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Payload byte available |
| wr_ready | output | 1 | Payload byte taken this cycle |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte taken |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| cs_n | output | 1 | Active-low chip select |

## Verification
The hardest situation to reach from the ports is the end of the status poll loop. The busy flag must stay set for exactly the right number of polls, so that both the last successful poll and the timeout boundary are reached. The bench models the EEPROM. Its model is loaded with a busy count for each write and sweeps that count from zero to past a small poll limit, using a short wait, so both sides of the limit and the one-past case are seen. Reads are swept over every address length and payload length around the frame-size limit, which also covers the refused requests.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_SHIFT,
        S_HAND,
        S_GAP,
        S_WAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        F_WREN,
        F_XFER,
        F_POLL
    } frame_e;

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = value;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/spi_char_shifter.sv
module spi_char_shifter #(
    parameter int CLK_DIV = 4,
    localparam int DW = $clog2(CLK_DIV + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi
);

    typedef struct packed {
        logic          busy;
        logic [DW-1:0] div;
        logic [2:0]    bits;
        logic          sclk;
        logic [7:0]    sh;
        logic [7:0]    rx;
        logic          done;
    } eng_t;

    eng_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.sh   = tx_byte;
                d.div  = '0;
                d.bits = '0;
                d.sclk = 1'b0;
            end
        end else if (q.div == DW'(CLK_DIV - 1)) begin
            d.div = '0;
            if (!q.sclk) begin
                d.sclk = 1'b1;
                d.rx   = {q.rx[6:0], miso};
            end else begin
                d.sclk = 1'b0;
                if (q.bits == 3'd7) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.bits = q.bits + 3'd1;
                    d.sh   = {q.sh[6:0], 1'b0};
                end
            end
        end else begin
            d.div = q.div + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done    = q.done;
    assign rx_byte = q.rx;
    assign sclk    = q.sclk;
    assign mosi    = q.sh[7];

endmodule

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq
    import spi_eeprom_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int ADDR_MAX   = 3,
    parameter int MAX_FRAME  = 260,
    parameter int POLL_LIMIT = 1000,
    parameter int POLL_WAIT  = 50000,
    localparam int ALEN_W = $clog2(ADDR_MAX + 1),
    localparam int FW     = $clog2(MAX_FRAME + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ALEN_W-1:0]     req_alen,
    input  logic [8*ADDR_MAX-1:0] req_addr,
    input  logic [FW-1:0]         req_len,
    output logic                  busy,
    output logic                  done,
    output logic                  err,
    input  logic [7:0]            wr_data,
    input  logic                  wr_valid,
    output logic                  wr_ready,
    output logic [7:0]            rd_data,
    output logic                  rd_valid,
    input  logic                  rd_ready,
    output logic                  sclk,
    output logic                  mosi,
    input  logic                  miso,
    output logic                  cs_n
);

    localparam int PCW = $clog2(POLL_LIMIT + 1);
    localparam int TW  = $clog2(POLL_WAIT + 2 * CLK_DIV + 1);
    localparam int TOTW = FW + 2;

    typedef struct packed {
        seq_state_e            st;
        frame_e                kind;
        logic                  wr;
        logic [ALEN_W-1:0]     alen;
        logic [FW-1:0]         len;
        logic [8*ADDR_MAX-1:0] addr;
        logic [FW-1:0]         idx;
        logic [FW-1:0]         flen;
        logic [PCW-1:0]        tries;
        logic                  busyflag;
        logic [7:0]            rdbuf;
        logic                  cs_n;
        logic                  done;
        logic                  err;
    } seq_t;

    seq_t d, q;

    logic          eng_start, eng_done;
    logic [7:0]    eng_tx, eng_rx;
    logic          tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;

    spi_char_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .tx_byte (eng_tx),
        .miso    (miso),
        .done    (eng_done),
        .rx_byte (eng_rx),
        .sclk    (sclk),
        .mosi    (mosi)
    );

    seq_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .value   (tmr_val),
        .expired (tmr_exp)
    );

    // byte chosen for the current frame position
    logic                  in_addr, in_data, need_wdata;
    logic [ALEN_W-1:0]     sel;
    logic [8*ADDR_MAX-1:0] ash;
    logic [TOTW-1:0]       total;
    logic                  last_byte, adv;

    always_comb begin
        in_addr    = (q.idx != '0) && (q.idx <= FW'(q.alen));
        in_data    = (q.idx > FW'(q.alen));
        sel        = q.alen - q.idx[ALEN_W-1:0];
        ash        = q.addr >> (8 * int'(sel));
        need_wdata = (q.kind == F_XFER) && q.wr && in_data;
        last_byte  = (q.idx + FW'(1) == q.flen);
        eng_tx     = 8'h00;
        case (q.kind)
            F_WREN: eng_tx = OP_WREN;
            F_POLL: eng_tx = (q.idx == '0) ? OP_RDSR : 8'h00;
            default: begin
                if (q.idx == '0)   eng_tx = q.wr ? OP_WRITE : OP_READ;
                else if (in_addr)  eng_tx = ash[7:0];
                else if (q.wr)     eng_tx = wr_data;
                else               eng_tx = 8'h00;
            end
        endcase
    end

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        eng_start = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        wr_ready  = 1'b0;
        adv       = 1'b0;
        total     = TOTW'(1) + TOTW'(req_alen) + TOTW'(req_len) + TOTW'(!req_write);

        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.wr       = req_write;
                    d.alen     = req_alen;
                    d.len      = req_len;
                    d.addr     = req_addr;
                    d.tries    = '0;
                    d.busyflag = 1'b0;
                    if ((int'(req_alen) > ADDR_MAX) || (int'(total) > MAX_FRAME)) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.err  = 1'b0;
                        d.kind = req_write ? F_WREN : F_XFER;
                        d.flen = req_write ? FW'(1) : FW'(total);
                        d.idx  = '0;
                        d.cs_n = 1'b0;
                        d.st   = S_LOAD;
                    end
                end
            end
            S_LOAD: begin
                wr_ready = need_wdata;
                if (!need_wdata || wr_valid) begin
                    eng_start = 1'b1;
                    d.st      = S_SHIFT;
                end
            end
            S_SHIFT: begin
                if (eng_done) begin
                    if (q.kind == F_POLL && q.idx == FW'(1))
                        d.busyflag = eng_rx[0];
                    if (q.kind == F_XFER && !q.wr && in_data && !last_byte) begin
                        d.rdbuf = eng_rx;
                        d.st    = S_HAND;
                    end else begin
                        adv = 1'b1;
                    end
                end
            end
            S_HAND: begin
                if (rd_ready) adv = 1'b1;
            end
            S_GAP: begin
                if (tmr_exp) begin
                    case (q.kind)
                        F_WREN: begin
                            d.kind = F_XFER;
                            d.idx  = '0;
                            d.flen = FW'(1) + FW'(q.alen) + q.len;
                            d.cs_n = 1'b0;
                            d.st   = S_LOAD;
                        end
                        F_XFER: begin
                            if (q.wr) begin
                                d.kind = F_POLL;
                                d.idx  = '0;
                                d.flen = FW'(2);
                                d.cs_n = 1'b0;
                                d.st   = S_LOAD;
                            end else begin
                                d.done = 1'b1;
                                d.err  = 1'b0;
                                d.st   = S_IDLE;
                            end
                        end
                        default: begin
                            if (!q.busyflag) begin
                                d.done = 1'b1;
                                d.err  = 1'b0;
                                d.st   = S_IDLE;
                            end else if (int'(q.tries) + 1 >= POLL_LIMIT) begin
                                d.done = 1'b1;
                                d.err  = 1'b1;
                                d.st   = S_IDLE;
                            end else begin
                                d.tries  = q.tries + PCW'(1);
                                tmr_load = 1'b1;
                                tmr_val  = TW'(POLL_WAIT);
                                d.st     = S_WAIT;
                            end
                        end
                    endcase
                end
            end
            S_WAIT: begin
                if (tmr_exp) begin
                    d.kind = F_POLL;
                    d.idx  = '0;
                    d.flen = FW'(2);
                    d.cs_n = 1'b0;
                    d.st   = S_LOAD;
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (adv) begin
            if (last_byte) begin
                d.cs_n   = 1'b1;
                d.st     = S_GAP;
                tmr_load = 1'b1;
                tmr_val  = TW'(2 * CLK_DIV);
            end else begin
                d.idx = q.idx + FW'(1);
                d.st  = S_LOAD;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy     = (q.st != S_IDLE);
    assign done     = q.done;
    assign err      = q.err;
    assign rd_valid = (q.st == S_HAND);
    assign rd_data  = q.rdbuf;
    assign cs_n     = q.cs_n;

endmodule

// File: rtl/spi_eeprom_seq_chk.sv
module spi_eeprom_seq_chk #(
    parameter int GAP_MIN = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       cs_n,
    input logic       sclk,
    input logic       mosi,
    input logic       wr_ready,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data
);

    localparam int GW = $clog2(GAP_MIN + 2);
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gap_q <= GW'(GAP_MIN);
        else if (!cs_n)
            gap_q <= '0;
        else if (int'(gap_q) < GAP_MIN)
            gap_q <= gap_q + GW'(1);
    end

    // R1
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R1
    mosi_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R2
    cs_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    // R2
    cs_gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (int'(gap_q) >= GAP_MIN));

    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R5
    wr_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !cs_n);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind spi_eeprom_seq spi_eeprom_seq_chk #(.GAP_MIN(2 * CLK_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .mosi     (mosi),
    .wr_ready (wr_ready),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data)
);

// File: tb/spi_eeprom_seq_bench.sv
`timescale 1ns/1ps
module spi_eeprom_seq_bench;

    localparam int DIV  = 2;
    localparam int AMAX = 2;
    localparam int MAXF = 12;
    localparam int PL   = 4;
    localparam int PW   = 20;
    localparam int AW   = $clog2(AMAX + 1);
    localparam int FW   = $clog2(MAXF + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic                req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0]       req_alen = '0;
    logic [8*AMAX-1:0]   req_addr = '0;
    logic [FW-1:0]       req_len = '0;
    logic                busy, done, err;
    logic [7:0]          wr_data;
    logic                wr_valid = 1'b0, wr_ready;
    logic [7:0]          rd_data;
    logic                rd_valid, rd_ready = 1'b0;
    logic                sclk, mosi, cs_n;
    logic                miso = 1'b1;

    spi_eeprom_seq #(.CLK_DIV(DIV), .ADDR_MAX(AMAX), .MAX_FRAME(MAXF),
                     .POLL_LIMIT(PL), .POLL_WAIT(PW)) u_spi_eeprom_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_alen(req_alen), .req_addr(req_addr), .req_len(req_len),
        .busy(busy), .done(done), .err(err),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int nchk = 0, nfail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] base_mem(input int i);
        return 8'(i * 37 + 11);
    endfunction

    function automatic logic [7:0] pay(input int seed, input int k);
        return 8'(seed + k * 29);
    endfunction

    // ---------------- device model ----------------
    logic [7:0] wmem [256];
    bit         wflag [256];
    int         fop [256], flen [256], fgap [256], faddr [256];
    bit         fbad [256];
    int         nf = 0;
    int         cur_alen = 0, cur_P = 0, cur_gap = 0;
    int         busy_left = 0;
    bit         wel = 0, stat_busy = 0, fbad_c = 0;
    logic       prev_cs = 1'b1, prev_sclk = 1'b0;
    logic [7:0] rsh = 0, msh = 8'hA5, mop = 0;
    logic [15:0] maddr = 0;
    int         bitsin = 0;

    function automatic logic [7:0] mem_rd(input int i);
        return wflag[i & 255] ? wmem[i & 255] : base_mem(i & 255);
    endfunction

    function automatic logic [7:0] out_byte(input int k);
        if (mop == 8'h03 && k > cur_alen)
            return mem_rd(int'(maddr) + k - 1 - cur_alen);
        if (mop == 8'h05 && k == 1)
            return {7'b0, stat_busy};
        return 8'hA5;
    endfunction

    always @(cs_n or sclk) begin
        if (prev_cs === 1'b1 && cs_n === 1'b0) begin
            bitsin = 0; maddr = 0; mop = 0; fbad_c = 0;
            stat_busy = (busy_left != 0);
            msh = 8'hA5; miso = msh[7];
            fgap[nf] = cur_gap;
        end
        if (cs_n === 1'b0 && prev_sclk === 1'b0 && sclk === 1'b1) begin
            rsh = {rsh[6:0], mosi};
            bitsin++;
            if (bitsin % 8 == 0) begin
                int j;
                j = bitsin / 8 - 1;
                if (j == 0) mop = rsh;
                else if (j <= cur_alen) maddr = {maddr[7:0], rsh};
                else if (mop == 8'h02) begin
                    wmem[(int'(maddr) + j - 1 - cur_alen) & 255] = rsh;
                    wflag[(int'(maddr) + j - 1 - cur_alen) & 255] = 1;
                end
                if (mop == 8'h05 && j == 1 && rsh != 8'h00) fbad_c = 1;
            end
        end
        if (cs_n === 1'b0 && prev_sclk === 1'b1 && sclk === 1'b0) begin
            if (bitsin % 8 == 0) msh = out_byte(bitsin / 8);
            else                 msh = {msh[6:0], 1'b0};
            miso = msh[7];
        end
        if (prev_cs === 1'b0 && cs_n === 1'b1) begin
            if (bitsin % 8 != 0) fbad_c = 1;
            fop[nf] = int'(mop); flen[nf] = bitsin / 8; faddr[nf] = int'(maddr);
            fbad[nf] = fbad_c;
            if (mop == 8'h06) wel = 1;
            if (mop == 8'h02) begin
                if (!wel) fbad[nf] = 1;
                wel = 0;
                busy_left = cur_P;
            end
            if (mop == 8'h05 && busy_left != 0) busy_left--;
            nf++;
        end
        prev_cs = cs_n;
        prev_sclk = sclk;
    end

    // ---------------- bus measurements ----------------
    int cyc = 0, hcnt = 0, sclk_bad = 0;
    always @(negedge clk) begin
        cyc++;
        rd_ready <= ((cyc % 3) != 1);
        wr_valid <= ((cyc % 4) != 2);
        if (cs_n) cur_gap++; else cur_gap = 0;
        if (sclk) hcnt++;
        else if (hcnt != 0) begin
            if (hcnt != DIV) sclk_bad++;
            hcnt = 0;
        end
    end

    int wk = 0, wbase = 0, wseed = 0;
    int nrd = 0;
    logic [7:0] rdat [1024];
    assign wr_data = pay(wseed, wk - wbase);

    always @(posedge clk) begin
        if (wr_valid && wr_ready) wk <= wk + 1;
        if (rd_valid && rd_ready) begin
            rdat[nrd & 1023] <= rd_data;
            nrd <= nrd + 1;
        end
    end

    // ---------------- request driver ----------------
    task automatic issue(input bit w, input int alen, input int addr, input int len,
                         input bit accept);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_alen = AW'(alen);
        req_addr = (8*AMAX)'(addr); req_len = FW'(len);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == accept, "R9 busy after request", int'(busy), int'(accept));
        while (!done) @(negedge clk);
    endtask

    task automatic do_read(input int alen, input int addr, input int len);
        int b0, r0, tot, amask, bad;
        bit acc;
        tot = 2 + alen + len;
        acc = (alen <= AMAX) && (tot <= MAXF);
        cur_alen = alen; b0 = nf; r0 = nrd;
        amask = (alen == 0) ? 0 : ((1 << (8 * alen)) - 1);
        issue(1'b0, alen, addr, len, acc);
        chk(err == !acc, "R8 read err flag", int'(err), int'(!acc));
        @(negedge clk);
        chk(!done, "R9 done one cycle", int'(done), 0);
        if (!acc) begin
            chk(nf == b0, "R8 no frame on refusal", nf - b0, 0);
            return;
        end
        chk(nf - b0 == 1 && fop[b0] == 3 && flen[b0] == tot && !fbad[b0],
            "R3 read frame op/len", flen[b0], tot);
        chk(faddr[b0] == (addr & amask), "R3 read address", faddr[b0], addr & amask);
        chk(nrd - r0 == len, "R4 read byte count", nrd - r0, len);
        bad = 0;
        for (int k = 0; k < len; k++)
            if (rdat[(r0 + k) & 1023] != mem_rd((addr & amask) + k)) bad++;
        chk(bad == 0, "R4 read data values", bad, 0);
    endtask

    task automatic do_write(input int alen, input int addr, input int len,
                            input int P, input int seed);
        int b0, np, tot, bad, gbad, pbad, amask;
        bit acc, eerr;
        tot = 1 + alen + len;
        acc = (tot <= MAXF);
        np = (P < PL) ? P + 1 : PL;
        eerr = !acc || (P >= PL);
        cur_alen = alen; cur_P = P; b0 = nf;
        wbase = wk; wseed = seed;
        amask = (1 << (8 * alen)) - 1;
        issue(1'b1, alen, addr, len, acc);
        chk(err == eerr, "R7 write err flag", int'(err), int'(eerr));
        if (!acc) begin
            chk(nf == b0, "R8 no frame on refusal", nf - b0, 0);
            return;
        end
        chk(nf - b0 == 2 + np, "R6 frame count incl polls", nf - b0, 2 + np);
        chk(fop[b0] == 6 && flen[b0] == 1, "R5 enable frame", fop[b0], 6);
        chk(fop[b0+1] == 2 && flen[b0+1] == tot && !fbad[b0+1] &&
            faddr[b0+1] == (addr & amask), "R5 write frame", flen[b0+1], tot);
        chk(wk - wbase == len, "R5 payload handshakes", wk - wbase, len);
        bad = 0;
        for (int k = 0; k < len; k++)
            if (mem_rd((addr & amask) + k) != pay(seed, k)) bad++;
        chk(bad == 0, "R5 stored payload", bad, 0);
        pbad = 0; gbad = 0;
        for (int f = b0 + 2; f < nf; f++) begin
            if (fop[f] != 5 || flen[f] != 2 || fbad[f]) pbad++;
            if (f >= b0 + 3 && fgap[f] < PW) gbad++;
        end
        for (int f = b0 + 1; f < nf; f++)
            if (fgap[f] < 2 * DIV) gbad++;
        chk(pbad == 0, "R6 poll frame shape", pbad, 0);
        chk(gbad == 0, "R7 inter-frame gaps", gbad, 0);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R10 bus idle in reset", int'({cs_n, sclk}), 2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !rd_valid && !wr_ready, "R10 reset state",
            int'({busy, done, rd_valid, wr_ready}), 0);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R2 idle chip select", int'(cs_n), 1);

        for (int a = 0; a <= 3; a++)
            for (int l = 0; l <= 10; l++)
                do_read(a, 16'h3C40 + 8 * l + a, l);

        for (int a = 1; a <= 2; a++)
            for (int li = 0; li < 2; li++)
                for (int p = 0; p <= PL + 1; p++)
                    do_write(a, 16'h5100 + 16 * p + 64 * li + a, 1 + 2 * li, p, 7 * p + a);

        do_write(2, 16'h0010, 10, 0, 3);
        do_read(2, 16'h5100 + 2, 4);
        do_read(1, 16'h0001 + 16 * 5, 3);

        chk(sclk_bad == 0, "R1 clock high width", sclk_bad, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL R9 watchdog act=%0d exp=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end

endmodule